// File: doc/BRIEF.md
# Image sensor register bring-up sequencer

This block configures an image sensor over a two-wire, I2C-style control bus once the chip is up. A single pulse on `start` launches a fixed nine-entry script of register writes. The first entry is a soft reset of the sensor. After it the block holds the bus idle for a programmable number of clock cycles. It then sets the resolution, output format, scaling, gain behaviour, test pattern, clocking and image orientation.

After every write except the reset, the block reads the same register back and compares the returned byte with the value it sent. A mismatch sets a sticky error flag and records which script entry failed. The run still continues to the end. Acknowledge bits from the sensor are sampled but have no effect, since sensors of this class may leave the ACK slot undriven.

Both bus lines are open-drain. The block only pulls a line low or releases it. The bit rate comes from the system clock through a quarter-period divider.

Top module: `cam_cfg_seq`

## Requirements
- R1: Every transaction opens with a device byte of 0x42 for writes and register-pointer setup, or 0x43 for the data-return phase of a read. No other device byte appears on the bus.
- R2: The register writes are issued in exactly this order as (register, value) pairs, with no extra writes: (0x12,0x80), (0x12,0x0E), (0x0C,0x08), (0x3E,0x08), (0x14,0x01), (0x40,0xD0), (0x42,0x08), (0x11,0xC0), (0x1E,0x30). Script entry numbers run 0 to 8 in this order.
- R3: Each of entries 1 to 8 is followed by a readback of its own register, before the next entry's write. The readback consists of a pointer transaction (START, 0x42, register, STOP), then START, 0x43, one byte returned by the sensor, a master NACK and STOP. Entry 0 has no readback, so a run performs exactly eight reads.
- R4: After the STOP that ends entry 0, at least RST_WAIT clock cycles pass before the next START.
- R5: If a returned byte differs from the value written for that entry, `err` goes high and stays high until the next accepted start. `err_idx` holds the entry number of the first failing entry. All remaining entries are still written and checked.
- R6: Whether the sensor drives ACK low or leaves it released has no effect on the bus traffic or the results.
- R7: `busy` is high from the cycle after an accepted start until the last readback is compared. `done` then goes high and `busy` low. An accepted start clears `done`, `err` and `err_idx`. A start pulse while `busy` is high is ignored.
- R8: While not busy, both line drivers are released. SCL falls every 4*QDIV clock cycles within a byte.
- R9: After reset, `busy`, `done`, `err`, `scl_lo` and `sda_lo` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that launches the script |
| sda_in | input | 1 | Sampled level of the data line |
| scl_lo | output | 1 | Pull the clock line low when 1 |
| sda_lo | output | 1 | Pull the data line low when 1 |
| busy | output | 1 | Script running |
| done | output | 1 | Script finished |
| err | output | 1 | Sticky readback mismatch flag |
| err_idx | output | 4 | Entry number of the first mismatch |

## Verification
The bench attaches a behavioural sensor model that stores written bytes and returns them on reads. The model can be told to corrupt chosen registers and to acknowledge or stay silent. A clean run with ACK shows the full script order and the read framing. The same run without ACK must give identical logs, which separates real ACK handling from ignoring it. Corrupting only the last entry, or only the entry that shares a register with the reset write, probes the edges of the index capture. Random corruption masks then confirm that the first failure is the one recorded. A start pulse injected mid-run must not add any writes.

// File: rtl/cam_cfg_seq.sv
module cam_cfg_seq #(
  parameter int QDIV     = 250,
  parameter int RST_WAIT = 100000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       sda_in,
  output logic       scl_lo,
  output logic       sda_lo,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [3:0] err_idx
);
  localparam int NENT = 9;
  localparam int DW   = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam int WW   = $clog2(RST_WAIT + 1);

  function automatic logic [15:0] entry(input logic [3:0] i);
    case (i)
      4'd0: entry = {8'h12, 8'h80};
      4'd1: entry = {8'h12, 8'h0E};
      4'd2: entry = {8'h0C, 8'h08};
      4'd3: entry = {8'h3E, 8'h08};
      4'd4: entry = {8'h14, 8'h01};
      4'd5: entry = {8'h40, 8'hD0};
      4'd6: entry = {8'h42, 8'h08};
      4'd7: entry = {8'h11, 8'hC0};
      4'd8: entry = {8'h1E, 8'h30};
      default: entry = 16'h0;
    endcase
  endfunction

  logic          run;
  logic [3:0]    idx, k, bitn;
  logic [1:0]    q;
  logic [DW-1:0] div;
  logic [WW-1:0] wcnt;
  logic [7:0]    rd, cur_byte, shb;
  logic [15:0]   cur;
  logic          is_start, is_stop, is_byte, tick, active;
  logic          scl_nx, sda_nx;

  assign cur      = entry(idx);
  assign is_start = (k == 4'd0) || (k == 4'd5) || (k == 4'd9);
  assign is_stop  = (k == 4'd4) || (k == 4'd8) || (k == 4'd12);
  assign is_byte  = !is_start && !is_stop;
  assign active   = run && (wcnt == '0);
  assign tick     = active && (div == DW'(QDIV - 1));
  assign busy     = run;

  always_comb begin
    case (k)
      4'd1, 4'd6: cur_byte = 8'h42;
      4'd2, 4'd7: cur_byte = cur[15:8];
      4'd3:       cur_byte = cur[7:0];
      4'd10:      cur_byte = 8'h43;
      default:    cur_byte = 8'hFF;
    endcase
  end

  assign shb = cur_byte << bitn[2:0];

  always_comb begin
    if (is_start) begin
      scl_nx = (q == 2'd3);
      sda_nx = (q >= 2'd2);
    end else if (is_stop) begin
      scl_nx = (q == 2'd0);
      sda_nx = (q <= 2'd1);
    end else begin
      scl_nx = (q == 2'd0) || (q == 2'd3);
      sda_nx = (bitn < 4'd8) && !shb[7];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_lo <= 1'b0;
      sda_lo <= 1'b0;
    end else begin
      scl_lo <= active && scl_nx;
      sda_lo <= active && sda_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; done <= 1'b0; err <= 1'b0; err_idx <= '0;
      idx <= '0; k <= '0; q <= '0; bitn <= '0;
      div <= '0; wcnt <= '0; rd <= '0;
    end else if (start && !run) begin
      run <= 1'b1; done <= 1'b0; err <= 1'b0; err_idx <= '0;
      idx <= '0; k <= '0; q <= '0; bitn <= '0; div <= '0;
    end else if (run) begin
      if (wcnt != '0) begin
        wcnt <= wcnt - 1'b1;
      end else begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) begin
          q <= q + 1'b1;
          if (k == 4'd11 && q == 2'd2 && bitn < 4'd8)
            rd <= {rd[6:0], sda_in};
          if (q == 2'd3) begin
            if (is_byte && bitn != 4'd8) begin
              bitn <= bitn + 1'b1;
            end else begin
              bitn <= '0;
              if (k == 4'd4 && idx == '0) begin
                k <= '0; idx <= 4'd1; wcnt <= WW'(RST_WAIT);
              end else if (k == 4'd12) begin
                if (rd != cur[7:0]) begin
                  err <= 1'b1;
                  if (!err) err_idx <= idx;
                end
                if (idx == 4'(NENT - 1)) begin
                  run <= 1'b0; done <= 1'b1;
                end else begin
                  idx <= idx + 1'b1; k <= '0;
                end
              end else begin
                k <= k + 1'b1;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/cam_cfg_seq_chk.sv
module cam_cfg_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       scl_lo,
  input logic       sda_lo,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [3:0] err_idx
);
  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  assert_idle_released_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_lo && !sda_lo));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $past(err)) |-> err);

  assert_idx_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $past(err)) |-> $stable(err_idx));

  assert_finish_done_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(start) && !$past(busy)) |-> (busy && !done && !err));
endmodule

bind cam_cfg_seq cam_cfg_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .scl_lo(scl_lo), .sda_lo(sda_lo),
  .busy(busy), .done(done), .err(err), .err_idx(err_idx)
);

// File: tb/cam_cfg_seq_tb.sv
module cam_cfg_seq_tb;
  localparam int CLK_P = 10;
  localparam int QD    = 4;
  localparam int RW    = 300;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic scl_lo, sda_lo, busy, done, err;
  logic [3:0] err_idx;
  logic slave_lo = 1'b0;
  logic ack_en = 1'b1;
  wire  scl_w = ~scl_lo;
  wire  sda_w = ~(sda_lo | slave_lo);

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  cam_cfg_seq #(.QDIV(QD), .RST_WAIT(RW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .sda_in(sda_w),
    .scl_lo(scl_lo), .sda_lo(sda_lo), .busy(busy), .done(done),
    .err(err), .err_idx(err_idx)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc++;

  logic [7:0] mem [256];
  logic [7:0] corrupt [256];
  logic [7:0] wr_reg [16], wr_dat [16], rd_reg [16];
  int n_wr, n_rd, n_badaddr, n_start, n_stop, n_fall;
  int t_stop1, t_start2, t_f2, t_f3;
  int bcnt = 0, bytecnt = 0;
  logic rdm = 1'b0;
  logic [7:0] sh = 8'h0, ptr = 8'h0, rbyte = 8'h0;

  function automatic logic [15:0] script(input int i);
    logic [7:0] r [9] = '{8'h12, 8'h12, 8'h0C, 8'h3E, 8'h14, 8'h40, 8'h42, 8'h11, 8'h1E};
    logic [7:0] d [9] = '{8'h80, 8'h0E, 8'h08, 8'h08, 8'h01, 8'hD0, 8'h08, 8'hC0, 8'h30};
    return {r[i], d[i]};
  endfunction

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    bcnt = 0; bytecnt = 0; rdm = 1'b0; slave_lo = 1'b0;
    n_start++;
    if (n_start == 2) t_start2 = cyc;
  end

  always @(posedge sda_w) if (scl_w === 1'b1) begin
    n_stop++;
    if (n_stop == 1) t_stop1 = cyc;
  end

  always @(negedge scl_w) begin
    n_fall++;
    if (n_fall == 2) t_f2 = cyc;
    if (n_fall == 3) t_f3 = cyc;
    if (rdm) slave_lo = (bcnt < 8) ? ~rbyte[7 - bcnt] : 1'b0;
    else     slave_lo = (bcnt == 8) ? ack_en : 1'b0;
  end

  always @(posedge scl_w) begin
    if (bcnt < 8) begin
      sh = {sh[6:0], sda_w};
      bcnt++;
    end else begin
      bcnt = 0;
      if (rdm) rdm = 1'b0;
      else begin
        if (bytecnt == 0) begin
          if (sh == 8'h43) begin
            rdm = 1'b1; rbyte = mem[ptr];
            if (n_rd < 16) rd_reg[n_rd] = ptr;
            n_rd++;
          end else if (sh != 8'h42) n_badaddr++;
        end else if (bytecnt == 1) ptr = sh;
        else if (bytecnt == 2) begin
          mem[ptr] = sh ^ corrupt[ptr];
          if (n_wr < 16) begin wr_reg[n_wr] = sh == sh ? ptr : ptr; wr_dat[n_wr] = sh; end
          n_wr++;
        end
        bytecnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_once(input logic [8:0] mask, input bit ack, input bit midstart);
    int first = -1;
    for (int i = 0; i < 256; i++) corrupt[i] = 8'h00;
    for (int i = 8; i >= 1; i--) if (mask[i]) begin
      logic [15:0] e = script(i);
      corrupt[e[15:8]] = 8'h5A;
      first = i;
    end
    ack_en = ack;
    n_wr = 0; n_rd = 0; n_badaddr = 0; n_start = 0; n_stop = 0; n_fall = 0;
    t_stop1 = 0; t_start2 = 0; t_f2 = 0; t_f3 = 0;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(posedge clk); #1;
    chk(busy === 1'b1 && done === 1'b0 && err === 1'b0, "R7 start accepted", {busy, done, err}, 3'b100);
    if (midstart) begin
      repeat (3000) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    while (done !== 1'b1 && !finished) @(posedge clk);
    #1;
    chk(n_wr == 9, "R2 write count", n_wr, 9);
    for (int i = 0; i < 9 && i < n_wr; i++) begin
      logic [15:0] e = script(i);
      chk({wr_reg[i], wr_dat[i]} == e, "R2 write order", {wr_reg[i], wr_dat[i]}, e);
    end
    chk(n_badaddr == 0, "R1 device byte", n_badaddr, 0);
    chk(n_rd == 8, "R3 read count", n_rd, 8);
    for (int i = 1; i <= 8 && i <= n_rd; i++) begin
      logic [15:0] e = script(i);
      chk(rd_reg[i-1] == e[15:8], "R3 readback register", rd_reg[i-1], e[15:8]);
    end
    chk(n_start == n_stop && n_start == 25, "R3 framing count", n_start, 25);
    chk(t_start2 - t_stop1 >= RW, "R4 reset wait", t_start2 - t_stop1, RW);
    chk(t_f3 - t_f2 == 4 * QD, "R8 scl period", t_f3 - t_f2, 4 * QD);
    chk(err === (first != -1), "R5 error flag", err, first != -1);
    if (first != -1) chk(err_idx == 4'(first), "R5 first index", err_idx, first);
    chk(busy === 1'b0, "R7 busy after done", busy, 0);
    chk(scl_lo === 1'b0 && sda_lo === 1'b0, "R8 released idle", {scl_lo, sda_lo}, 0);
    repeat (5) @(posedge clk);
  endtask

  initial begin
    int unsigned seed = $urandom(32'd1234);
    seed = seed;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    chk(busy === 0 && done === 0 && err === 0 && scl_lo === 0 && sda_lo === 0,
        "R9 reset state", {busy, done, err, scl_lo, sda_lo}, 0);
    run_once(9'h000, 1'b1, 1'b0);
    run_once(9'h000, 1'b0, 1'b0); // R6 silent sensor
    run_once(9'h100, 1'b1, 1'b0);
    run_once(9'h002, 1'b0, 1'b0);
    run_once(9'h000, 1'b1, 1'b1); // R7 start while busy
    for (int r = 0; r < 3; r++) begin
      logic [8:0] m = 9'($urandom) & 9'h1FE;
      run_once(m, 1'($urandom), 1'($urandom));
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    while (cyc < 190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule